// File: doc/BRIEF.md
# Trace Bank Multiplexer with Time-Division Pin Output

This block sends internal signals off chip to an external capture instrument. Several equal-width signal banks come in side by side. A select input picks one of them at run time, and that word is driven onto a group of trace data pins together with a trace clock pin. No captured data is stored on chip: every sample leaves through the pins as it arrives.

The pin rate is fixed when the block is built. At single rate, one bank word equal to the pin width goes out every clock. At double rate, each bank word is twice the pin width. The block is then clocked by a pin clock that runs at twice the word rate and is phase-aligned with it. The lower half of each word goes out first and the upper half second, and bank data is sampled only on the first pin cycle after reset and on every second pin cycle after that.

An enable input gates the output. While disabled, the data pins read zero, the output-enable flag is low and the trace clock stays low. A build option, allowed only for asynchronous sampling, keeps the output permanently on from reset with bank 0 selected. Double rate is allowed only for synchronous sampling. Illegal parameter combinations are rejected when the design is elaborated.

Top module: `trace_bank_mux`

## Requirements
- R1: While reset is asserted and on release, the data pins are zero, the trace clock is low, and the output-enable flag is low when always-on is not built in.
- R2: At single rate, the data pins after a clock edge equal the bank word selected at that edge when the enable input was high at that edge.
- R3: The select value s picks input bits [s*BANK_W +: BANK_W] of the packed bank input, for every s from 0 to the bank count minus one.
- R4: At double rate, the bank width is twice the pin count. The word sampled on a word-start cycle appears as its low half [PIN_W-1:0] on the pins after that edge.
- R5: At double rate, the upper half of the captured word appears on the pins one pin cycle after the low half. Changes to select, data or enable during the second half cycle have no effect on that word.
- R6: While the output is disabled, the data pins are all zero.
- R7: The trace clock toggles on every pin cycle that carries an enabled word. It is held low while the output is disabled.
- R8: In always-on mode, the output-enable flag is high from reset onward, bank 0 is the selected bank after reset, and the enable input has no effect.
- R9: The output-enable flag follows the enable input only at word boundaries: one edge later at single rate, and only at word-start edges at double rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pin clock (word rate at single rate, twice the word rate at double rate) |
| rst_n | input | 1 | Active-low synchronous reset |
| trace_en | input | 1 | Output enable request, sampled at word boundaries |
| bank_sel | input | SEL_W | Run-time bank index |
| bank_data | input | NUM_BANKS*BANK_W | All signal banks packed, bank s at bits [s*BANK_W +: BANK_W] |
| trace_pins | output | PIN_W | Trace data pins |
| trace_oe | output | 1 | Output drivers enabled |
| trace_clk | output | 1 | Trace clock, one edge per pin word |

## Verification
Three builds are exercised side by side: single rate, double rate, and always-on. A directed sweep of all select values with distinct bytes per bank shows that the right slice is routed and that banks are not swapped or shifted. Random data, select and enable that change on every pin cycle check, at double rate, that the second half-cycle ignores its inputs and that the halves come out in the right order. Long enabled and disabled runs check that the trace clock toggles and is gated, and that the always-on build ignores the enable input.

// File: rtl/tbm_pkg.sv
`timescale 1ns/1ps
package tbm_pkg;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } half_e;

    function automatic int sel_width(input int banks);
        return (banks > 1) ? $clog2(banks) : 1;
    endfunction

endpackage

// File: rtl/tbm_bank_select.sv
`timescale 1ns/1ps
module tbm_bank_select #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 8,
    parameter int SEL_W     = 2
) (
    input  logic [NUM_BANKS*BANK_W-1:0] bank_data,
    input  logic [SEL_W-1:0]            bank_sel,
    output logic [BANK_W-1:0]           word
);

    logic [BANK_W-1:0] banks [NUM_BANKS];

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_split
        assign banks[g] = bank_data[g*BANK_W +: BANK_W];
    end

    if (NUM_BANKS == 1) begin : g_single
        assign word = banks[0];
    end else begin : g_multi
        assign word = banks[bank_sel];
    end

endmodule

// File: rtl/tbm_phase_ctrl.sv
`timescale 1ns/1ps
module tbm_phase_ctrl
    import tbm_pkg::*;
#(
    parameter bit TDM2X = 1'b0
) (
    input  logic  clk,
    input  logic  rst_n,
    output half_e phase,
    output logic  word_start
);

    half_e phase_d, phase_q;

    always_comb begin
        if (TDM2X) begin
            phase_d = (phase_q == PH_LOW) ? PH_HIGH : PH_LOW;
        end else begin
            phase_d = PH_LOW;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_LOW;
        end else begin
            phase_q <= phase_d;
        end
    end

    assign phase      = phase_q;
    assign word_start = (phase_q == PH_LOW);

endmodule

// File: rtl/tbm_pin_drive.sv
`timescale 1ns/1ps
module tbm_pin_drive #(
    parameter int PIN_W     = 8,
    parameter int BANK_W    = 8,
    parameter bit ALWAYS_ON = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_start,
    input  logic              en_now,
    input  logic [BANK_W-1:0] word,
    output logic [PIN_W-1:0]  pins,
    output logic              oe,
    output logic              tclk
);

    typedef struct packed {
        logic [PIN_W-1:0] pins;
        logic [PIN_W-1:0] upper;
        logic             act;
        logic             tclk;
    } drv_s;

    drv_s s_d, s_q;

    logic [PIN_W-1:0] lo_half, hi_half;

    assign lo_half = word[PIN_W-1:0];
    assign hi_half = word[BANK_W-1 -: PIN_W];

    always_comb begin
        s_d = s_q;
        if (word_start) begin
            s_d.act   = en_now;
            s_d.upper = hi_half;
            s_d.pins  = en_now ? lo_half : '0;
        end else begin
            s_d.pins  = s_q.act ? s_q.upper : '0;
        end
        s_d.tclk = s_d.act ? ~s_q.tclk : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{pins: '0, upper: '0, act: ALWAYS_ON, tclk: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign pins = s_q.pins;
    assign oe   = s_q.act;
    assign tclk = s_q.tclk;

endmodule

// File: rtl/trace_bank_mux.sv
`timescale 1ns/1ps
module trace_bank_mux
    import tbm_pkg::*;
#(
    parameter int PIN_W     = 8,
    parameter int NUM_BANKS = 4,
    parameter bit TDM2X     = 1'b0,
    parameter bit SYNC_MODE = 1'b1,
    parameter bit ALWAYS_ON = 1'b0,
    localparam int RATE     = TDM2X ? 2 : 1,
    localparam int BANK_W   = PIN_W * RATE,
    localparam int SEL_W    = sel_width(NUM_BANKS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        trace_en,
    input  logic [SEL_W-1:0]            bank_sel,
    input  logic [NUM_BANKS*BANK_W-1:0] bank_data,
    output logic [PIN_W-1:0]            trace_pins,
    output logic                        trace_oe,
    output logic                        trace_clk
);

    // Build-time legality of the parameter set
    if (PIN_W < 4 || PIN_W > 64) begin : g_bad_pin_count
        $error("trace_bank_mux: pin count must lie in 4..64");
    end
    if (NUM_BANKS < 1 || NUM_BANKS > 64 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_bank_count
        $error("trace_bank_mux: bank count must be a power of two from 1 to 64");
    end
    if (TDM2X && !SYNC_MODE) begin : g_bad_rate
        $error("trace_bank_mux: double rate needs synchronous sampling");
    end
    if (ALWAYS_ON && SYNC_MODE) begin : g_bad_always_on
        $error("trace_bank_mux: always-on needs asynchronous sampling");
    end

    half_e             phase_w;
    logic              word_start_w;
    logic              en_now_w;
    logic [BANK_W-1:0] word_w;

    assign en_now_w = ALWAYS_ON | trace_en;

    tbm_phase_ctrl #(
        .TDM2X (TDM2X)
    ) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase_w),
        .word_start (word_start_w)
    );

    tbm_bank_select #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W),
        .SEL_W     (SEL_W)
    ) u_select (
        .bank_data (bank_data),
        .bank_sel  (bank_sel),
        .word      (word_w)
    );

    tbm_pin_drive #(
        .PIN_W     (PIN_W),
        .BANK_W    (BANK_W),
        .ALWAYS_ON (ALWAYS_ON)
    ) u_drive (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_start (word_start_w),
        .en_now     (en_now_w),
        .word       (word_w),
        .pins       (trace_pins),
        .oe         (trace_oe),
        .tclk       (trace_clk)
    );

endmodule

// File: rtl/tbm_checker.sv
`timescale 1ns/1ps
module tbm_checker
    import tbm_pkg::*;
#(
    parameter int PIN_W     = 8,
    parameter bit TDM2X     = 1'b0,
    parameter bit ALWAYS_ON = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trace_en,
    input logic [PIN_W-1:0] trace_pins,
    input logic             trace_oe,
    input logic             trace_clk,
    input half_e            phase
);

    logic started_q;

    always_ff @(posedge clk) begin
        if (!rst_n) started_q <= 1'b0;
        else        started_q <= 1'b1;
    end

    assert_idle_pins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !trace_oe |-> (trace_pins == '0));

    assert_clk_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !trace_oe |-> !trace_clk);

    assert_clk_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && trace_oe && $past(trace_oe)) |-> (trace_clk != $past(trace_clk)));

    assert_always_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ALWAYS_ON != 1'b0) |-> trace_oe);

    assert_oe_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (TDM2X != 1'b0 && phase == PH_HIGH) |=> $stable(trace_oe));

    assert_oe_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (TDM2X == 1'b0 && started_q) |-> (trace_oe == $past(trace_en || ALWAYS_ON)));

endmodule

bind trace_bank_mux tbm_checker #(
    .PIN_W     (PIN_W),
    .TDM2X     (TDM2X),
    .ALWAYS_ON (ALWAYS_ON)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trace_en   (trace_en),
    .trace_pins (trace_pins),
    .trace_oe   (trace_oe),
    .trace_clk  (trace_clk),
    .phase      (phase_w)
);

// File: tb/trace_bank_mux_tb_top.sv
`timescale 1ns/1ps
module trace_bank_mux_tb_top;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n;
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    // A: single rate, 8 pins, 4 banks
    logic        a_en;
    logic [1:0]  a_sel;
    logic [31:0] a_data;
    logic [7:0]  a_pins;
    logic        a_oe, a_tclk;
    // B: double rate, 4 pins, 4 banks of 8 bits
    logic        b_en;
    logic [1:0]  b_sel;
    logic [31:0] b_data;
    logic [3:0]  b_pins;
    logic        b_oe, b_tclk;
    // C: always-on, single rate, 8 pins, 2 banks
    logic        c_en;
    logic [0:0]  c_sel;
    logic [15:0] c_data;
    logic [7:0]  c_pins;
    logic        c_oe, c_tclk;

    trace_bank_mux #(.PIN_W(8), .NUM_BANKS(4), .TDM2X(1'b0), .SYNC_MODE(1'b1), .ALWAYS_ON(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .trace_en(a_en), .bank_sel(a_sel), .bank_data(a_data),
        .trace_pins(a_pins), .trace_oe(a_oe), .trace_clk(a_tclk));

    trace_bank_mux #(.PIN_W(4), .NUM_BANKS(4), .TDM2X(1'b1), .SYNC_MODE(1'b1), .ALWAYS_ON(1'b0)) dut2x_i (
        .clk(clk), .rst_n(rst_n), .trace_en(b_en), .bank_sel(b_sel), .bank_data(b_data),
        .trace_pins(b_pins), .trace_oe(b_oe), .trace_clk(b_tclk));

    trace_bank_mux #(.PIN_W(8), .NUM_BANKS(2), .TDM2X(1'b0), .SYNC_MODE(1'b0), .ALWAYS_ON(1'b1)) dutao_i (
        .clk(clk), .rst_n(rst_n), .trace_en(c_en), .bank_sel(c_sel), .bank_data(c_data),
        .trace_pins(c_pins), .trace_oe(c_oe), .trace_clk(c_tclk));

    // Expected values
    logic [7:0] ea_pins, ec_pins;
    logic [3:0] eb_pins, b_hi;
    logic       ea_oe, ea_tclk, eb_oe, eb_tclk, ec_oe, ec_tclk;
    logic       b_ph, b_act, b_upper;

    function automatic logic [7:0] pick(input logic [31:0] flat, input int sel);
        return flat[sel*8 +: 8];
    endfunction

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_step();
        logic [7:0] w;
        ea_oe   = a_en;
        ea_pins = a_en ? pick(a_data, int'(a_sel)) : 8'h00;
        ea_tclk = a_en ? ~ea_tclk : 1'b0;
        b_upper = b_ph;
        if (!b_ph) begin
            w       = pick(b_data, int'(b_sel));
            b_act   = b_en;
            eb_pins = b_en ? w[3:0] : 4'h0;
            b_hi    = w[7:4];
        end else begin
            eb_pins = b_act ? b_hi : 4'h0;
        end
        eb_oe   = b_act;
        eb_tclk = b_act ? ~eb_tclk : 1'b0;
        b_ph    = ~b_ph;
        ec_pins = pick({16'h0, c_data}, int'(c_sel));
        ec_oe   = 1'b1;
        ec_tclk = ~ec_tclk;
    endtask

    task automatic compare();
        if (ea_oe) chk("R2", "A pins (R3 select)", a_pins, ea_pins);
        else       chk("R6", "A pins idle", a_pins, ea_pins);
        chk("R9", "A oe", {7'h0, a_oe}, {7'h0, ea_oe});
        chk("R7", "A trace clk", {7'h0, a_tclk}, {7'h0, ea_tclk});
        if (b_upper) chk("R5", "B upper half", {4'h0, b_pins}, {4'h0, eb_pins});
        else         chk("R4", "B lower half", {4'h0, b_pins}, {4'h0, eb_pins});
        chk("R9", "B oe", {7'h0, b_oe}, {7'h0, eb_oe});
        chk("R7", "B trace clk", {7'h0, b_tclk}, {7'h0, eb_tclk});
        chk("R8", "C pins", c_pins, ec_pins);
        chk("R8", "C oe", {7'h0, c_oe}, {7'h0, ec_oe});
        chk("R8", "C trace clk", {7'h0, c_tclk}, {7'h0, ec_tclk});
    endtask

    task automatic cycle();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        a_en = 0; a_sel = 0; a_data = 0;
        b_en = 0; b_sel = 0; b_data = 0;
        c_en = 0; c_sel = 0; c_data = 0;
        ea_pins = 0; ea_oe = 0; ea_tclk = 0;
        eb_pins = 0; eb_oe = 0; eb_tclk = 0; b_hi = 0; b_act = 0; b_ph = 0; b_upper = 0;
        ec_pins = 0; ec_oe = 1; ec_tclk = 0;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1", "A pins reset", a_pins, 8'h00);
        chk("R1", "A oe reset", {7'h0, a_oe}, 8'h00);
        chk("R1", "A clk reset", {7'h0, a_tclk}, 8'h00);
        chk("R1", "B pins reset", {4'h0, b_pins}, 8'h00);
        chk("R1", "B oe reset", {7'h0, b_oe}, 8'h00);
        chk("R8", "C oe during reset", {7'h0, c_oe}, 8'h01);
        chk("R1", "C pins reset", c_pins, 8'h00);
        rst_n = 1'b1;

        // R8: bank 0 right after reset with enable low
        c_data = 16'hB7A5;
        cycle();
        chk("R8", "C bank 0 after reset", c_pins, 8'hA5);

        // R3: directed sweep of every select value with distinct bytes
        for (int s = 0; s < 4; s++) begin
            a_en = 1; a_sel = 2'(s); a_data = 32'hD4C3B2A1;
            b_en = 1; b_sel = 2'(s); b_data = 32'h8E6C4A29;
            c_sel = 1'(s); c_data = 16'h5A3C;
            cycle();
            chk("R3", "A sweep", a_pins, pick(32'hD4C3B2A1, s));
            cycle();
        end

        // R5: hold a word on B, then scramble inputs during its second half
        while (b_ph) cycle();
        b_en = 1; b_sel = 2'd2; b_data = 32'h00C50000;
        cycle();
        chk("R4", "B low half directed", {4'h0, b_pins}, 8'h05);
        b_en = 0; b_sel = 2'd1; b_data = 32'hFFFFFFFF;
        cycle();
        chk("R5", "B high half ignores late inputs", {4'h0, b_pins}, 8'h0C);

        // R6/R7: long disabled stretch
        a_en = 0; b_en = 0;
        repeat (6) cycle();

        // Random mix
        for (int i = 0; i < 600; i++) begin
            a_en   = ($urandom % 5) != 0;
            a_sel  = 2'($urandom);
            a_data = $urandom;
            b_en   = ($urandom % 5) != 0;
            b_sel  = 2'($urandom);
            b_data = $urandom;
            c_en   = 1'($urandom);
            c_sel  = 1'($urandom);
            c_data = 16'($urandom);
            cycle();
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule